// File: doc/BRIEF.md
# Four-Lane Demultiplexing Registered Transceiver

The block takes one shared A-side data word and presents it on four B-side output lanes. Each lane holds its own storage element. While the lane's latch enable is high, the element is transparent. While the latch enable is low, it either holds its value or loads A on a rising clock edge. A shared active-low clock enable goes to exactly one lane, and a two-bit lane select picks that lane. Software or a bus controller can therefore load the lanes one at a time from the same narrow source.

Each lane has an output gate. The gate drives the lane only when a global active-low enable and the lane's own active-low enable are both asserted. High impedance is not modelled with tristate nets. Each lane instead carries a drive-valid flag, and the lane's data is forced to zero whenever that flag is low. The data width is a parameter. An asynchronous active-low reset clears every lane's stored value.

Top module: `demux_reg_xcvr`

## Requirements
- R1: While `lat_en[i]` is high, lane i shows the current `a_data` in the same cycle, whatever the clock does.
- R2: When `lat_en[i]` falls with no capture on that edge, lane i keeps the last `a_data` value it saw while the enable was high.
- R3: When `lat_en[i]` is low, `clk_en_n` is low and `ce_sel` selects lane i, lane i loads `a_data` on the rising clock edge.
- R4: When `lat_en[i]` is low and `clk_en_n` is high, lane i keeps its stored value across clock edges.
- R5: `ce_sel` is decoded as a binary lane number: 0 selects lane 0, 1 selects lane 1, 2 selects lane 2 and 3 selects lane 3. A clock edge does not change any unselected lane whose latch enable is low.
- R6: `b_drive[i]` is 1 exactly when `oe_all_n` and `oe_lane_n[i]` are both 0.
- R7: While `b_drive[i]` is 0, lane i's data field reads zero, and the lane's stored value is unaffected.
- R8: While `rst_n` is low, every lane's stored value is zero.
- R9: Any number of latch enables may be high at once, and every such lane passes `a_data` at the same time.
- Lane i occupies bits `[i*DATA_W +: DATA_W]` of `b_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_data | input | DATA_W | Shared A-side data word |
| lat_en | input | 4 | Per-lane latch enable, high = transparent |
| clk_en_n | input | 1 | Shared active-low clock enable |
| ce_sel | input | 2 | Lane that receives the clock enable |
| oe_all_n | input | 1 | Global active-low output enable |
| oe_lane_n | input | 4 | Per-lane active-low output enable |
| b_data | output | 4*DATA_W | Lane data, lane i at bits [i*DATA_W +: DATA_W] |
| b_drive | output | 4 | Per-lane drive-valid flag (0 = high impedance) |

## Verification
The assertions assume that `a_data`, `lat_en`, `clk_en_n` and `ce_sel` are stable around the rising clock edge. Under that assumption, the value sampled on an edge is the value a lane stores. The capture and hold properties also assume that the previous cycle was out of reset. The bench changes every input only on the falling edge and leaves one full clock cycle after reset release before it relies on a previous-cycle relation.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned LANES = 4;
  localparam int unsigned SEL_W = $clog2(LANES);
endpackage

// File: rtl/ce_lane_decode.sv
module ce_lane_decode
  import xcvr_pkg::*;
(
  input  logic             clk_en_n,
  input  logic [SEL_W-1:0] ce_sel,
  output logic [LANES-1:0] ce_hit
);
  for (genvar g = 0; g < LANES; g++) begin : g_dec
    assign ce_hit[g] = ~clk_en_n & (ce_sel == SEL_W'(g));
  end
endmodule

// File: rtl/lane_store.sv
module lane_store #(
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a_data,
  input  logic              lat_en,
  input  logic              ce_hit,
  output logic [DATA_W-1:0] q,
  output logic [DATA_W-1:0] val
);
  logic              load;
  logic [DATA_W-1:0] q_nxt;

  always_comb begin
    load  = lat_en | ce_hit;
    q_nxt = load ? a_data : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  assign val = lat_en ? a_data : q;
endmodule

// File: rtl/lane_out_gate.sv
module lane_out_gate #(
  parameter int unsigned DATA_W = 4
) (
  input  logic [DATA_W-1:0] val,
  input  logic              oe_all_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] data,
  output logic              drive
);
  always_comb begin
    drive = ~(oe_all_n | oe_n);
    data  = drive ? val : '0;
  end
endmodule

// File: rtl/demux_reg_xcvr.sv
module demux_reg_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned DATA_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DATA_W-1:0]       a_data,
  input  logic [LANES-1:0]        lat_en,
  input  logic                    clk_en_n,
  input  logic [SEL_W-1:0]        ce_sel,
  input  logic                    oe_all_n,
  input  logic [LANES-1:0]        oe_lane_n,
  output logic [LANES*DATA_W-1:0] b_data,
  output logic [LANES-1:0]        b_drive
);
  logic [LANES-1:0]             ce_hit;
  logic [LANES-1:0][DATA_W-1:0] lane_q;
  logic [LANES-1:0][DATA_W-1:0] lane_val;

  ce_lane_decode u_dec (
    .clk_en_n (clk_en_n),
    .ce_sel   (ce_sel),
    .ce_hit   (ce_hit)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_store #(.DATA_W(DATA_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_data (a_data),
      .lat_en (lat_en[g]),
      .ce_hit (ce_hit[g]),
      .q      (lane_q[g]),
      .val    (lane_val[g])
    );
    lane_out_gate #(.DATA_W(DATA_W)) u_gate (
      .val      (lane_val[g]),
      .oe_all_n (oe_all_n),
      .oe_n     (oe_lane_n[g]),
      .data     (b_data[g*DATA_W +: DATA_W]),
      .drive    (b_drive[g])
    );
  end
endmodule

// File: rtl/demux_reg_xcvr_chk.sv
module demux_reg_xcvr_chk
  import xcvr_pkg::*;
#(
  parameter int unsigned DATA_W = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [DATA_W-1:0]            a_data,
  input logic [LANES-1:0]             lat_en,
  input logic                         clk_en_n,
  input logic [SEL_W-1:0]             ce_sel,
  input logic                         oe_all_n,
  input logic [LANES*DATA_W-1:0]      b_data,
  input logic [LANES-1:0]             b_drive,
  input logic [LANES-1:0]             ce_hit,
  input logic [LANES-1:0][DATA_W-1:0] lane_q
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r5_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ce_hit));
  a_r5_idle_none: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |-> (ce_hit == '0));
  a_r6_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_all_n |-> (b_drive == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    a_r1_transparent: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_en[g] && b_drive[g]) |-> (b_data[g*DATA_W +: DATA_W] == a_data));
    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(!lat_en[g] && !clk_en_n && ce_sel == SEL_W'(g)))
        |-> (lane_q[g] == $past(a_data)));
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(!lat_en[g] && clk_en_n)) |-> $stable(lane_q[g]));
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !b_drive[g] |-> (b_data[g*DATA_W +: DATA_W] == '0));
  end
endmodule

bind demux_reg_xcvr demux_reg_xcvr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .a_data   (a_data),
  .lat_en   (lat_en),
  .clk_en_n (clk_en_n),
  .ce_sel   (ce_sel),
  .oe_all_n (oe_all_n),
  .b_data   (b_data),
  .b_drive  (b_drive),
  .ce_hit   (ce_hit),
  .lane_q   (lane_q)
);

// File: tb/demux_reg_xcvr_bench.sv
module demux_reg_xcvr_bench;
  localparam int W = 4;
  localparam int L = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [W-1:0]   a_data;
  logic [L-1:0]   lat_en;
  logic           clk_en_n;
  logic [1:0]     ce_sel;
  logic           oe_all_n;
  logic [L-1:0]   oe_lane_n;
  logic [L*W-1:0] b_data;
  logic [L-1:0]   b_drive;

  int tests = 0;
  int fails = 0;
  logic [W-1:0] mdl [L];

  always #5 clk = ~clk;

  demux_reg_xcvr #(.DATA_W(W)) u_demux_reg_xcvr (
    .clk(clk), .rst_n(rst_n), .a_data(a_data), .lat_en(lat_en),
    .clk_en_n(clk_en_n), .ce_sel(ce_sel), .oe_all_n(oe_all_n),
    .oe_lane_n(oe_lane_n), .b_data(b_data), .b_drive(b_drive)
  );

  task automatic chk(string tag, int lane, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s lane %0d %s: actual %0d expected %0d", tag, lane, what, act, exp);
    end
  endtask

  // Compare all lanes against the model with the current inputs applied.
  task automatic compare(string tag);
    for (int i = 0; i < L; i++) begin
      logic         drv;
      logic [W-1:0] v;
      drv = !oe_all_n && !oe_lane_n[i];
      v   = lat_en[i] ? a_data : mdl[i];
      chk(tag, i, "drive", int'(b_drive[i]), int'(drv));
      chk(tag, i, "data", int'(b_data[i*W +: W]), drv ? int'(v) : 0);
    end
  endtask

  // Apply inputs on the falling edge, check, then advance the model over a rising edge.
  task automatic cyc(string tag, logic [L-1:0] le, logic cen, logic [1:0] sel,
                     logic [W-1:0] a, logic oea, logic [L-1:0] oel);
    @(negedge clk);
    lat_en = le; clk_en_n = cen; ce_sel = sel; a_data = a;
    oe_all_n = oea; oe_lane_n = oel;
    #1;
    compare(tag);
    @(posedge clk);
    for (int i = 0; i < L; i++)
      if (le[i] || (!cen && sel == 2'(i))) mdl[i] = a;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; a_data = '0; lat_en = '0; clk_en_n = 1'b1; ce_sel = '0;
    oe_all_n = 1'b0; oe_lane_n = '0;
    for (int i = 0; i < L; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    // R8: reset contents are zero, visible while driven
    #1 compare("R8");
    @(negedge clk) rst_n = 1'b1;
    cyc("R8", 4'b0000, 1'b1, 2'd0, 4'hF, 1'b0, 4'b0000);

    // R1: lane 0 transparent across edges with changing data
    for (int k = 0; k < 4; k++) cyc("R1", 4'b0001, 1'b1, 2'd1, 4'(k*3+1), 1'b0, 4'b0000);
    // R2: enable drops, later data ignored
    cyc("R2", 4'b0001, 1'b1, 2'd0, 4'h5, 1'b0, 4'b0000);
    cyc("R2", 4'b0000, 1'b1, 2'd0, 4'hA, 1'b0, 4'b0000);
    cyc("R2", 4'b0000, 1'b1, 2'd0, 4'h3, 1'b0, 4'b0000);
    // R3 / R5: capture into each selected lane in turn
    for (int s = 0; s < 4; s++) begin
      cyc("R3", 4'b0000, 1'b0, 2'(s), 4'(8+s), 1'b0, 4'b0000);
      cyc("R5", 4'b0000, 1'b1, 2'(s), 4'h0, 1'b0, 4'b0000);
    end
    // R4: clock enable inactive, no lane changes
    for (int k = 0; k < 3; k++) cyc("R4", 4'b0000, 1'b1, 2'(k), 4'(k+12), 1'b0, 4'b0000);
    // R9: several lanes transparent together
    cyc("R9", 4'b1011, 1'b1, 2'd0, 4'h6, 1'b0, 4'b0000);
    cyc("R9", 4'b1111, 1'b1, 2'd0, 4'h9, 1'b0, 4'b0000);
    // R6 / R7: output enable combinations, storage kept while undriven
    cyc("R6", 4'b0000, 1'b1, 2'd0, 4'h1, 1'b1, 4'b0000);
    cyc("R7", 4'b0000, 1'b0, 2'd2, 4'h4, 1'b0, 4'b0101);
    cyc("R7", 4'b0000, 1'b1, 2'd2, 4'h0, 1'b0, 4'b0000);
    cyc("R6", 4'b0000, 1'b1, 2'd0, 4'h2, 1'b1, 4'b1111);

    // Sweep: every latch-enable pattern, select and clock enable, rotating output enables
    for (int le = 0; le < 16; le++)
      for (int s = 0; s < 4; s++)
        for (int c = 0; c < 2; c++)
          cyc("R5", 4'(le), 1'(c), 2'(s), 4'((le*5 + s*3 + c) & 15),
              1'(((le + s) % 7) == 0), 4'((le ^ (s*5)) & (c ? 4'hF : 4'h6)));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule